// File: doc/BRIEF.md
# RV32I Single-Cycle Main Control Decoder

This block is the main controller of a single-cycle RV32I datapath. It is purely combinational. It looks at one 32-bit instruction word and drives every steering signal the datapath needs for that instruction in the same cycle:

- the register-file write enable;
- the writeback source;
- the two ALU operand selects and the ALU operation;
- the immediate format;
- the data-memory strobes and the access width/sign code;
- the three bits that choose the next PC: Branch, Jump and InvZero.

Conditional branches need no separate comparator. The ALU computes either a subtraction (BEQ/BNE) or a set-less-than (BLT/BGE and their unsigned forms). The datapath then forms the taken condition from the ALU zero flag as `Branch & ((~zero) ^ InvZero)`. The controller's job is to pick the operation and the polarity.

Any instruction outside the supported set drives every output to zero. This covers an unknown opcode and a funct3 or funct7 value that a supported opcode does not define. A zeroed instruction writes nothing, reads nothing and does not redirect the PC.

Top module: `rvctl_main`

## Requirements
- R1: Opcode bits [6:0] are decoded as follows: 0000011 load, 0100011 store, 1100011 branch, 1101111 JAL, 1100111 JALR, 0010111 AUIPC, 0010011 OP-IMM, 0110011 OP. The following are illegal and drive every output to 0: any other opcode, a load funct3 of 011/110/111, a store funct3 above 010, a branch funct3 of 010/011, a JALR funct3 other than 000, an OP funct7 other than 0000000 or 0100000 (the latter only with funct3 000 or 101), and an OP-IMM shift whose funct7 is not allowed (SLLI needs 0000000; SRLI/SRAI need 0000000 or 0100000).
- R2: `rf_we` is 1 for legal loads, JAL, JALR, AUIPC, OP-IMM and OP, and 0 for stores and branches.
- R3: `wb_sel` is 0 (ALU result) for AUIPC, OP-IMM and OP; 1 (memory data) for loads; 2 (PC+4) for JAL and JALR; and 0 when `rf_we` is 0.
- R4: A load drives the following: `alu_op` ADD, `a_sel`=0 (rs1), `b_sel`=1 (immediate), `imm_sel` I, `mem_rd`=1, and `mem_size` equal to funct3. In `mem_size`, bit 2 set means zero-extend, and bits [1:0] give 0 for byte, 1 for halfword and 2 for word.
- R5: A store drives `mem_wr`=1, `alu_op` ADD, `a_sel`=0, `b_sel`=1, `imm_sel` S and `mem_size` equal to funct3.
- R6: AUIPC drives `a_sel`=1 (PC), `b_sel`=1, `imm_sel` U and `alu_op` ADD.
- R7: JAL drives `jump`=1, `imm_sel` J, `a_sel`=0 and `b_sel`=0. JALR drives `jump`=1, `imm_sel` I, `a_sel`=0 and `b_sel`=1. Neither drives `branch`.
- R8: BEQ (funct3 000) and BNE (001) drive `branch`=1, `alu_op` SUB, `a_sel`=0, `b_sel`=0 and `imm_sel` B. BEQ sets `inv_zero`=1 and BNE sets `inv_zero`=0.
- R9: BLT (100) and BGE (101) select SLT, and BLTU (110) and BGEU (111) select SLTU. The less-than forms set `inv_zero`=0 and the greater-or-equal forms set `inv_zero`=1. All four drive `branch`=1, `b_sel`=0 and `imm_sel` B.
- R10: For OP and OP-IMM, the operation follows funct3: 000 ADD (SUB for OP with funct7 0100000), 001 SLL, 010 SLT, 011 SLTU, 100 XOR, 101 SRL (SRA with funct7 0100000), 110 OR, 111 AND. The `alu_op` codes are ADD 0, SUB 1, SLL 2, SLT 3, SLTU 4, XOR 5, SRL 6, SRA 7, OR 8, AND 9. OP-IMM uses `b_sel`=1 and `imm_sel` I. OP uses `b_sel`=0 and `imm_sel` 0. The `imm_sel` codes are I 0, S 1, B 2, U 3, J 4.
- R11: `mem_rd` and `mem_wr` are never both 1. Both are 0, and `mem_size` is 0, for every instruction that is not a load or store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word being executed |
| rf_we | output | 1 | Register-file write enable |
| wb_sel | output | 2 | Writeback source: 0 ALU, 1 memory, 2 PC+4 |
| a_sel | output | 1 | ALU operand A: 0 rs1, 1 PC |
| b_sel | output | 1 | ALU operand B: 0 rs2, 1 immediate |
| alu_op | output | 4 | ALU operation code |
| imm_sel | output | 3 | Immediate format select |
| mem_rd | output | 1 | Data-memory read strobe |
| mem_wr | output | 1 | Data-memory write strobe |
| mem_size | output | 3 | Access width and extension code |
| branch | output | 1 | Conditional branch in progress |
| jump | output | 1 | Unconditional jump in progress |
| inv_zero | output | 1 | Polarity of the ALU zero flag for branches |

## Verification
The block has no state, so any fault in its decode shows on the ports in the same cycle the instruction word is presented. A class decoder that matches two opcodes, or none, shows up as mixed strobes, for example `mem_wr` together with `rf_we`. It can also show as a supported instruction that comes out all zero. A wrong polarity in the branch table flips `inv_zero` for exactly one funct3 value. A missing legality term leaves nonzero outputs on an encoding that must be silent. The sweep presents every opcode against every funct3 and four funct7 patterns. It compares each output field separately, so the failing field and encoding are named directly.

// File: rtl/rvctl_pkg.sv
package rvctl_pkg;

  localparam int ILEN   = 32;
  localparam int OPC_W  = 7;
  localparam int F3_W   = 3;
  localparam int F7_W   = 7;
  localparam int AOP_W  = 4;
  localparam int IMM_W  = 3;
  localparam int WB_W   = 2;
  localparam int SIZE_W = 3;

  // instruction classes, one bit each in the class vector
  localparam int CL_LOAD   = 0;
  localparam int CL_STORE  = 1;
  localparam int CL_BRANCH = 2;
  localparam int CL_JAL    = 3;
  localparam int CL_JALR   = 4;
  localparam int CL_AUIPC  = 5;
  localparam int CL_OPIMM  = 6;
  localparam int CL_OP     = 7;
  localparam int CLS_N     = 8;

  localparam logic [OPC_W-1:0] OPC_TABLE [CLS_N] = '{
    7'b0000011, 7'b0100011, 7'b1100011, 7'b1101111,
    7'b1100111, 7'b0010111, 7'b0010011, 7'b0110011
  };

  localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

  typedef enum logic [AOP_W-1:0] {
    AOP_ADD  = 4'd0, AOP_SUB = 4'd1, AOP_SLL = 4'd2, AOP_SLT = 4'd3,
    AOP_SLTU = 4'd4, AOP_XOR = 4'd5, AOP_SRL = 4'd6, AOP_SRA = 4'd7,
    AOP_OR   = 4'd8, AOP_AND = 4'd9
  } aop_e;

  typedef enum logic [IMM_W-1:0] {
    IMF_I = 3'd0, IMF_S = 3'd1, IMF_B = 3'd2, IMF_U = 3'd3, IMF_J = 3'd4
  } imf_e;

  typedef enum logic [WB_W-1:0] {
    WBS_ALU = 2'd0, WBS_MEM = 2'd1, WBS_PC4 = 2'd2
  } wbs_e;

  typedef struct packed {
    logic              rf_we;
    wbs_e              wb_sel;
    logic              a_sel;
    logic              b_sel;
    aop_e              alu_op;
    imf_e              imm_sel;
    logic              mem_rd;
    logic              mem_wr;
    logic [SIZE_W-1:0] mem_size;
    logic              branch;
    logic              jump;
    logic              inv_zero;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{
    rf_we: 1'b0, wb_sel: WBS_ALU, a_sel: 1'b0, b_sel: 1'b0,
    alu_op: AOP_ADD, imm_sel: IMF_I, mem_rd: 1'b0, mem_wr: 1'b0,
    mem_size: '0, branch: 1'b0, jump: 1'b0, inv_zero: 1'b0
  };

  // legal load widths: B, H, W, BU, HU
  function automatic logic load_width_ok(input logic [F3_W-1:0] f3);
    return (f3[1:0] != 2'b11) && !(f3[2] && f3[1]);
  endfunction

  // legal store widths: B, H, W
  function automatic logic store_width_ok(input logic [F3_W-1:0] f3);
    return !f3[2] && (f3[1:0] != 2'b11);
  endfunction

endpackage

// File: rtl/rvctl_class.sv
module rvctl_class
  import rvctl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output logic [CLS_N-1:0] cls
);
  for (genvar g = 0; g < CLS_N; g++) begin : g_match
    assign cls[g] = (opcode == OPC_TABLE[g]);
  end

  always_comb begin
    p_class_onehot_r1: assert ($onehot0(cls));
  end
endmodule

// File: rtl/rvctl_arith.sv
module rvctl_arith
  import rvctl_pkg::*;
(
  input  logic [F3_W-1:0] f3,
  input  logic [F7_W-1:0] f7,
  input  logic            reg_form,
  output aop_e            op,
  output logic            ok
);
  logic f7_base, f7_alt;
  assign f7_base = (f7 == F7_BASE);
  assign f7_alt  = (f7 == F7_ALT);

  always_comb begin
    op = AOP_ADD;
    ok = 1'b1;
    unique case (f3)
      3'b000: begin
        op = (reg_form && f7_alt) ? AOP_SUB : AOP_ADD;
        ok = !reg_form || f7_base || f7_alt;
      end
      3'b001: begin
        op = AOP_SLL;
        ok = f7_base;
      end
      3'b101: begin
        op = f7_alt ? AOP_SRA : AOP_SRL;
        ok = f7_base || f7_alt;
      end
      3'b010: begin op = AOP_SLT;  ok = !reg_form || f7_base; end
      3'b011: begin op = AOP_SLTU; ok = !reg_form || f7_base; end
      3'b100: begin op = AOP_XOR;  ok = !reg_form || f7_base; end
      3'b110: begin op = AOP_OR;   ok = !reg_form || f7_base; end
      default: begin op = AOP_AND; ok = !reg_form || f7_base; end
    endcase
  end

  always_comb begin
    if (!reg_form) p_imm_no_sub_r10: assert (op != AOP_SUB);
  end
endmodule

// File: rtl/rvctl_cond.sv
module rvctl_cond
  import rvctl_pkg::*;
(
  input  logic [F3_W-1:0] f3,
  output aop_e            op,
  output logic            inv_zero,
  output logic            ok
);
  // f3[2]: ordered compare; f3[1]: unsigned; f3[0]: complementary sense
  logic ordered;
  assign ordered = f3[2];
  assign ok      = ordered || !f3[1];

  always_comb begin
    if (!ordered)    op = AOP_SUB;
    else if (f3[1])  op = AOP_SLTU;
    else             op = AOP_SLT;
  end

  // equality: taken on zero difference, so InvZero is set for BEQ
  // ordering: taken on nonzero less-than, so InvZero is set for BGE[U]
  assign inv_zero = ordered ? f3[0] : !f3[0];

  always_comb begin
    if (ok && !ordered) p_eq_uses_sub_r8: assert (op == AOP_SUB);
    if (ok && ordered)  p_ord_uses_slt_r9: assert (op == AOP_SLT || op == AOP_SLTU);
  end
endmodule

// File: rtl/rvctl_main.sv
module rvctl_main
  import rvctl_pkg::*;
(
  input  logic [ILEN-1:0]   instr,
  output logic              rf_we,
  output logic [WB_W-1:0]   wb_sel,
  output logic              a_sel,
  output logic              b_sel,
  output logic [AOP_W-1:0]  alu_op,
  output logic [IMM_W-1:0]  imm_sel,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [SIZE_W-1:0] mem_size,
  output logic              branch,
  output logic              jump,
  output logic              inv_zero
);
  logic [OPC_W-1:0] opcode;
  logic [F3_W-1:0]  f3;
  logic [F7_W-1:0]  f7;
  assign opcode = instr[OPC_W-1:0];
  assign f3     = instr[14:12];
  assign f7     = instr[31:25];

  logic unused_fields;
  assign unused_fields = ^{instr[24:15], instr[11:7]};

  logic [CLS_N-1:0] cls;
  rvctl_class u_class (.opcode(opcode), .cls(cls));

  aop_e arith_op;
  logic arith_ok;
  rvctl_arith u_arith (
    .f3(f3), .f7(f7), .reg_form(cls[CL_OP]), .op(arith_op), .ok(arith_ok)
  );

  aop_e cmp_op;
  logic cmp_inv, cmp_ok;
  rvctl_cond u_cond (.f3(f3), .op(cmp_op), .inv_zero(cmp_inv), .ok(cmp_ok));

  // per-class legality of the secondary fields
  logic [CLS_N-1:0] field_ok;
  always_comb begin
    field_ok            = '1;
    field_ok[CL_LOAD]   = load_width_ok(f3);
    field_ok[CL_STORE]  = store_width_ok(f3);
    field_ok[CL_BRANCH] = cmp_ok;
    field_ok[CL_JALR]   = (f3 == '0);
    field_ok[CL_OPIMM]  = arith_ok;
    field_ok[CL_OP]     = arith_ok;
  end

  logic legal;
  assign legal = |(cls & field_ok);

  ctl_t c;
  always_comb begin
    c = CTL_IDLE;
    if (legal) begin
      if (cls[CL_LOAD]) begin
        c.rf_we = 1'b1; c.wb_sel = WBS_MEM; c.b_sel = 1'b1;
        c.imm_sel = IMF_I; c.mem_rd = 1'b1; c.mem_size = f3;
      end
      if (cls[CL_STORE]) begin
        c.b_sel = 1'b1; c.imm_sel = IMF_S; c.mem_wr = 1'b1; c.mem_size = f3;
      end
      if (cls[CL_BRANCH]) begin
        c.alu_op = cmp_op; c.imm_sel = IMF_B;
        c.branch = 1'b1; c.inv_zero = cmp_inv;
      end
      if (cls[CL_JAL]) begin
        c.rf_we = 1'b1; c.wb_sel = WBS_PC4; c.imm_sel = IMF_J; c.jump = 1'b1;
      end
      if (cls[CL_JALR]) begin
        c.rf_we = 1'b1; c.wb_sel = WBS_PC4; c.b_sel = 1'b1;
        c.imm_sel = IMF_I; c.jump = 1'b1;
      end
      if (cls[CL_AUIPC]) begin
        c.rf_we = 1'b1; c.a_sel = 1'b1; c.b_sel = 1'b1; c.imm_sel = IMF_U;
      end
      if (cls[CL_OPIMM]) begin
        c.rf_we = 1'b1; c.b_sel = 1'b1; c.alu_op = arith_op; c.imm_sel = IMF_I;
      end
      if (cls[CL_OP]) begin
        c.rf_we = 1'b1; c.alu_op = arith_op;
      end
    end
  end

  assign rf_we    = c.rf_we;
  assign wb_sel   = c.wb_sel;
  assign a_sel    = c.a_sel;
  assign b_sel    = c.b_sel;
  assign alu_op   = c.alu_op;
  assign imm_sel  = c.imm_sel;
  assign mem_rd   = c.mem_rd;
  assign mem_wr   = c.mem_wr;
  assign mem_size = c.mem_size;
  assign branch   = c.branch;
  assign jump     = c.jump;
  assign inv_zero = c.inv_zero;

  always_comb begin
    if (cls == '0) p_unknown_silent_r1: assert (!rf_we && !mem_rd && !mem_wr && !branch && !jump);
    if (mem_wr) p_store_no_we_r2: assert (!rf_we);
    if (branch) p_branch_no_we_r2: assert (!rf_we);
    if (wb_sel == WBS_PC4) p_pc4_only_jump_r3: assert (jump && rf_we);
    if (mem_rd) p_load_reads_mem_r4: assert (wb_sel == WBS_MEM);
    if (a_sel) p_pc_operand_auipc_r6: assert (cls[CL_AUIPC]);
    p_flow_excl_r7: assert (!(branch && jump));
    p_mem_excl_r11: assert (!(mem_rd && mem_wr));
    if (!mem_rd && !mem_wr) p_size_idle_r11: assert (mem_size == '0);
  end
endmodule

// File: tb/tb_rvctl_main.sv
module tb_rvctl_main;
  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic [31:0] instr;
  logic        rf_we, a_sel, b_sel, mem_rd, mem_wr, branch, jump, inv_zero;
  logic [1:0]  wb_sel;
  logic [3:0]  alu_op;
  logic [2:0]  imm_sel, mem_size;

  rvctl_main dut (
    .instr(instr), .rf_we(rf_we), .wb_sel(wb_sel), .a_sel(a_sel), .b_sel(b_sel),
    .alu_op(alu_op), .imm_sel(imm_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_size(mem_size), .branch(branch), .jump(jump), .inv_zero(inv_zero)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // expected fields
  logic       e_we, e_a, e_b, e_rd, e_wr, e_br, e_j, e_inv;
  logic [1:0] e_wb;
  logic [3:0] e_op;
  logic [2:0] e_imm, e_size;
  logic       e_legal;
  string      e_tag;

  task automatic check(input string tag, input string fld, input int act, input int exp, input logic [31:0] w);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s instr=%08h actual=%0d expected=%0d", tag, fld, w, act, exp);
    end
  endtask

  // independent model written from the requirement text
  task automatic model(input logic [31:0] w);
    logic [6:0] op = w[6:0];
    logic [2:0] f3 = w[14:12];
    logic [6:0] f7 = w[31:25];
    e_we = 0; e_a = 0; e_b = 0; e_rd = 0; e_wr = 0; e_br = 0; e_j = 0; e_inv = 0;
    e_wb = 0; e_op = 0; e_imm = 0; e_size = 0; e_legal = 0; e_tag = "R1";
    case (op)
      7'h03: if (f3 inside {0, 1, 2, 4, 5}) begin
        e_legal = 1; e_tag = "R4";
        e_we = 1; e_wb = 1; e_b = 1; e_imm = 0; e_rd = 1; e_size = f3;
      end
      7'h23: if (f3 <= 2) begin
        e_legal = 1; e_tag = "R5";
        e_b = 1; e_imm = 1; e_wr = 1; e_size = f3;
      end
      7'h63: if (f3 != 2 && f3 != 3) begin
        e_legal = 1; e_br = 1; e_imm = 2;
        case (f3)
          0: begin e_tag = "R8"; e_op = 1; e_inv = 1; end
          1: begin e_tag = "R8"; e_op = 1; e_inv = 0; end
          4: begin e_tag = "R9"; e_op = 3; e_inv = 0; end
          5: begin e_tag = "R9"; e_op = 3; e_inv = 1; end
          6: begin e_tag = "R9"; e_op = 4; e_inv = 0; end
          default: begin e_tag = "R9"; e_op = 4; e_inv = 1; end
        endcase
      end
      7'h6f: begin
        e_legal = 1; e_tag = "R7"; e_we = 1; e_wb = 2; e_imm = 4; e_j = 1;
      end
      7'h67: if (f3 == 0) begin
        e_legal = 1; e_tag = "R7"; e_we = 1; e_wb = 2; e_b = 1; e_imm = 0; e_j = 1;
      end
      7'h17: begin
        e_legal = 1; e_tag = "R6"; e_we = 1; e_a = 1; e_b = 1; e_imm = 3;
      end
      7'h13, 7'h33: begin
        bit rr = (op == 7'h33);
        bit alt = (f7 == 7'h20);
        bit base = (f7 == 7'h00);
        int table_op [8] = '{0, 2, 3, 4, 5, 6, 8, 9};
        e_op = table_op[f3];
        if (f3 == 0 && rr && alt) e_op = 1;
        if (f3 == 5 && alt) e_op = 7;
        if (f3 == 1) e_legal = base;
        else if (f3 == 5 || f3 == 0) e_legal = base || alt || (f3 == 0 && !rr);
        else e_legal = base || !rr;
        if (e_legal) begin
          e_tag = "R10"; e_we = 1; e_b = !rr;
        end else e_op = 0;
      end
      default: ;
    endcase
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr <= w;
    @(negedge clk);
    model(w);
    begin
      string mt = e_legal ? ((e_rd || e_wr) ? e_tag : "R11") : "R1";
      string we_t = e_legal ? "R2" : "R1";
      string wb_t = e_legal ? "R3" : "R1";
      check(we_t, "rf_we", rf_we, e_we, w);
      check(wb_t, "wb_sel", wb_sel, e_wb, w);
      check(e_tag, "a_sel", a_sel, e_a, w);
      check(e_tag, "b_sel", b_sel, e_b, w);
      check(e_tag, "alu_op", alu_op, e_op, w);
      check(e_tag, "imm_sel", imm_sel, e_imm, w);
      check(mt, "mem_rd", mem_rd, e_rd, w);
      check(mt, "mem_wr", mem_wr, e_wr, w);
      check(mt, "mem_size", mem_size, e_size, w);
      check(e_tag, "branch", branch, e_br, w);
      check(e_tag, "jump", jump, e_j, w);
      check(e_tag, "inv_zero", inv_zero, e_inv, w);
    end
  endtask

  initial begin
    instr = 32'h0;
    // all-zero word: unknown opcode, everything quiet (R1)
    apply(32'h0000_0000);
    // sweep: every opcode x funct3 x four funct7 patterns
    for (int op = 0; op < 128; op++) begin
      for (int f3 = 0; f3 < 8; f3++) begin
        for (int k = 0; k < 4; k++) begin
          logic [6:0] f7v;
          logic [4:0] rs2, rs1, rd;
          case (k)
            0: f7v = 7'h00;
            1: f7v = 7'h20;
            2: f7v = 7'h01;
            default: f7v = 7'h7f;
          endcase
          rs2 = 5'(op * 3 + k);
          rs1 = 5'(f3 * 7 + op);
          rd  = 5'(op ^ (f3 << 2) ^ k);
          apply({f7v, rs2, rs1, 3'(f3), rd, 7'(op)});
        end
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule